// File: doc/BRIEF.md
# Page Mapping Table Programmer

This block fills a virtual-to-physical page translation table for a cached external-memory window. A caller presents one request: a memory target code, a virtual start address, a physical start address, a page size in kilobytes, a page count and a fixed flag. The block validates the request before it touches the table. A rejected request returns an error code and leaves the table untouched. An accepted request is expanded into a run of table writes, one entry per clock. Each entry holds a two-bit target code and a 16-bit physical page number.

Without the fixed flag, the physical page number steps up by one for each virtual page. With the fixed flag, every virtual page in the run points at the same physical page. A separate clear command returns every entry to the invalid state, so software can rebuild the map from scratch. The table is a register array, and a combinational read port exposes any entry. Address translation and cache maintenance belong to neighbouring blocks.

Top module: `pmt_programmer`

## Requirements
- R1: After reset `busy`, `done` and `status` are 0, and every entry reads as target 0 (invalid) with physical page 0xFFFF.
- R2: A page size other than 64 (kilobytes) is rejected with status 3. `done` is high in the cycle that follows the request, and `status` is only ever 0, 2, 3 or 4 when `done` is high.
- R3: A virtual or physical address with any of its low 16 bits set is rejected with status 2.
- R4: A virtual address below the window base `VBASE`, or a start page ((vaddr-VBASE)>>16) plus the count above `DEPTH`, is rejected with status 4.
- R5: When several checks fail, only the first is reported, in the order page size, then alignment, then range.
- R6: A rejected request writes no entry.
- R7: An accepted request with count N>0 writes entries start page .. start page+N-1, one per cycle, in the N cycles after the request. `busy` is high during those cycles. `done` is high for one cycle with `status` 0 in the cycle after the last write. With N=0, `done` and `status` 0 come one cycle after the request, and nothing is written.
- R8: With the fixed flag at 0, entry start+i gets physical page (paddr>>16)+i, taken modulo 2^16.
- R9: With the fixed flag at 1, every entry of the run gets physical page paddr>>16.
- R10: Each written entry stores the request's target code (0 invalid, 1 flash, 2 external RAM). Code 3 is stored as 0.
- R11: When the block is idle, `init_req` sets every entry to target 0 and page 0xFFFF in one clock. It takes precedence over a `req_valid` in the same cycle, which is then dropped without `done`. While the block is busy, `init_req` is ignored.
- R12: A request presented while `busy` is high is ignored.
- R13: Entries outside the written run keep their previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Invalidate every table entry |
| req_valid | input | 1 | Request strobe, one cycle |
| req_target | input | 2 | Memory target code (0 invalid, 1 flash, 2 external RAM) |
| req_vaddr | input | 32 | Virtual start address |
| req_paddr | input | 32 | Physical start address |
| req_psize_kb | input | 16 | Page size in kilobytes |
| req_count | input | CNT_W | Number of pages to map |
| req_fixed | input | 1 | 1: all pages alias one physical page |
| busy | output | 1 | Run of writes in progress |
| done | output | 1 | Completion pulse |
| status | output | 3 | Result code, valid with `done` |
| rd_idx | input | IDX_W | Table read index |
| rd_target | output | 2 | Target code of the entry read |
| rd_ppage | output | 16 | Physical page of the entry read |

## Verification
The embedded assertions check, on every cycle, the properties that do not depend on a particular request. Write indices and physical pages advance by one per cycle in the linear mode and stay still in the aliasing mode. A rejection never coincides with a write. A clear leaves the table's end entries invalid. Reported codes stay inside the legal set. Other behaviours can only be shown by the bench's scenarios, because each depends on one request and on the table contents: the priority between checks, the exact range boundary, wrap of the physical page, the exact completion cycle, and that entries outside a run or writes blocked while busy leave the table unchanged. For these, the bench sweeps every start page and count over a 16-entry table and compares the whole table against an arithmetic model after every request.

// File: rtl/pmt_pkg.sv
`timescale 1ns/1ps
package pmt_pkg;
    localparam int PPN_W = 16;

    localparam logic [1:0] TGT_NONE  = 2'd0;
    localparam logic [1:0] TGT_FLASH = 2'd1;
    localparam logic [1:0] TGT_XRAM  = 2'd2;

    typedef enum logic [2:0] {
        ST_OK    = 3'd0,
        ST_ALIGN = 3'd2,
        ST_SIZE  = 3'd3,
        ST_RANGE = 3'd4
    } st_e;

    typedef struct packed {
        logic [1:0]       tgt;
        logic [PPN_W-1:0] ppage;
    } entry_t;

    localparam entry_t ENTRY_NONE = '{tgt: TGT_NONE, ppage: 16'hFFFF};
endpackage

// File: rtl/pmt_check.sv
`timescale 1ns/1ps
module pmt_check
    import pmt_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          CNT_W      = 16,
    parameter int          DEPTH      = 64,
    parameter logic [31:0] VBASE      = 32'h3C00_0000,
    parameter int          PAGE_KB    = 64,
    parameter int          PAGE_SHIFT = 16,
    localparam int         IDX_W      = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [15:0]       psize_kb,
    input  logic [CNT_W-1:0]  count,
    output st_e               verdict,
    output logic [IDX_W-1:0]  vpage,
    output logic [PPN_W-1:0]  ppage
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << PAGE_SHIFT) - 64'd1);

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W:0]   span;
    logic              size_bad, align_bad, range_bad;

    always_comb begin
        offset    = vaddr - ADDR_W'(VBASE);
        span      = ({1'b0, offset} >> PAGE_SHIFT) + (ADDR_W+1)'(count);
        size_bad  = psize_kb != 16'(PAGE_KB);
        align_bad = (|(vaddr & LOW_MASK)) || (|(paddr & LOW_MASK));
        range_bad = (vaddr < ADDR_W'(VBASE)) || (span > (ADDR_W+1)'(DEPTH));
        vpage     = IDX_W'(offset >> PAGE_SHIFT);
        ppage     = PPN_W'(paddr >> PAGE_SHIFT);
        if (size_bad)       verdict = ST_SIZE;
        else if (align_bad) verdict = ST_ALIGN;
        else if (range_bad) verdict = ST_RANGE;
        else                verdict = ST_OK;
    end
endmodule

// File: rtl/pmt_seq.sv
`timescale 1ns/1ps
module pmt_seq
    import pmt_pkg::*;
#(
    parameter int  CNT_W = 16,
    parameter int  DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_req,
    input  logic             req_valid,
    input  logic [1:0]       req_target,
    input  logic [CNT_W-1:0] req_count,
    input  logic             req_fixed,
    input  st_e              verdict,
    input  logic [IDX_W-1:0] start_vpage,
    input  logic [PPN_W-1:0] start_ppage,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output entry_t           wr_entry,
    output logic             clr,
    output logic             busy,
    output logic             done,
    output st_e              status
);
    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [PPN_W-1:0] ppage;
        logic [CNT_W-1:0] left;
        logic             fixed;
        logic [1:0]       tgt;
        logic             done;
        st_e              status;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        wr_en    = q.busy;
        wr_idx   = q.idx;
        wr_entry = '{tgt: q.tgt, ppage: q.ppage};
        clr      = !q.busy && init_req;
        if (q.busy) begin
            d.left = q.left - 1'b1;
            d.idx  = q.idx + 1'b1;
            if (!q.fixed) d.ppage = q.ppage + 1'b1;
            if (q.left == CNT_W'(1)) begin
                d.busy   = 1'b0;
                d.done   = 1'b1;
                d.status = ST_OK;
            end
        end else if (init_req) begin
            d.done = 1'b0;
        end else if (req_valid) begin
            if (verdict != ST_OK) begin
                d.done   = 1'b1;
                d.status = verdict;
            end else if (req_count == '0) begin
                d.done   = 1'b1;
                d.status = ST_OK;
            end else begin
                d.busy  = 1'b1;
                d.idx   = start_vpage;
                d.ppage = start_ppage;
                d.left  = req_count;
                d.fixed = req_fixed;
                d.tgt   = (req_target == 2'd3) ? TGT_NONE : req_target;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, idx: '0, ppage: '0, left: '0, fixed: 1'b0,
                   tgt: TGT_NONE, done: 1'b0, status: ST_OK};
        end else begin
            q <= d;
        end
    end

    assign busy   = q.busy;
    assign done   = q.done;
    assign status = q.status;

    // R7
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> wr_idx == IDX_W'($past(wr_idx) + 1'b1));

    // R8
    linear_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && !q.fixed) |-> wr_entry.ppage == PPN_W'($past(wr_entry.ppage) + 1'b1));

    // R9
    alias_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && q.fixed) |-> $stable(wr_entry.ppage));

    // R7
    write_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !done);
endmodule

// File: rtl/pmt_table.sv
`timescale 1ns/1ps
module pmt_table
    import pmt_pkg::*;
#(
    parameter int  DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  entry_t           wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output entry_t           rd_entry
);
    entry_t mem_q [DEPTH];
    entry_t mem_d [DEPTH];

    always_comb begin
        for (int e = 0; e < DEPTH; e++) begin
            if (clr)                                   mem_d[e] = ENTRY_NONE;
            else if (wr_en && wr_idx == IDX_W'(e))     mem_d[e] = wr_entry;
            else                                       mem_d[e] = mem_q[e];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) mem_q[e] <= ENTRY_NONE;
        end else begin
            for (int e = 0; e < DEPTH; e++) mem_q[e] <= mem_d[e];
        end
    end

    always_comb begin
        if (int'(rd_idx) < DEPTH) rd_entry = mem_q[rd_idx];
        else                      rd_entry = ENTRY_NONE;
    end

    // R11
    clear_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mem_q[0] == ENTRY_NONE && mem_q[DEPTH-1] == ENTRY_NONE));
endmodule

// File: rtl/pmt_programmer.sv
`timescale 1ns/1ps
module pmt_programmer
    import pmt_pkg::*;
#(
    parameter int          CNT_W = 16,
    parameter int          DEPTH = 64,
    parameter logic [31:0] VBASE = 32'h3C00_0000,
    localparam int         IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_req,
    input  logic             req_valid,
    input  logic [1:0]       req_target,
    input  logic [31:0]      req_vaddr,
    input  logic [31:0]      req_paddr,
    input  logic [15:0]      req_psize_kb,
    input  logic [CNT_W-1:0] req_count,
    input  logic             req_fixed,
    output logic             busy,
    output logic             done,
    output logic [2:0]       status,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_target,
    output logic [15:0]      rd_ppage
);
    st_e              verdict, st;
    logic [IDX_W-1:0] start_vpage, wr_idx;
    logic [PPN_W-1:0] start_ppage;
    logic             wr_en, clr;
    entry_t           wr_entry, rd_entry;

    pmt_check #(.ADDR_W(32), .CNT_W(CNT_W), .DEPTH(DEPTH), .VBASE(VBASE),
                .PAGE_KB(64), .PAGE_SHIFT(16)) u_check (
        .vaddr(req_vaddr), .paddr(req_paddr), .psize_kb(req_psize_kb),
        .count(req_count), .verdict(verdict), .vpage(start_vpage), .ppage(start_ppage)
    );

    pmt_seq #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .req_valid(req_valid),
        .req_target(req_target), .req_count(req_count), .req_fixed(req_fixed),
        .verdict(verdict), .start_vpage(start_vpage), .start_ppage(start_ppage),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry), .clr(clr),
        .busy(busy), .done(done), .status(st)
    );

    pmt_table #(.DEPTH(DEPTH)) u_table (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_entry(wr_entry), .rd_idx(rd_idx), .rd_entry(rd_entry)
    );

    assign status    = st;
    assign rd_target = rd_entry.tgt;
    assign rd_ppage  = rd_entry.ppage;

    // R6
    reject_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 3'd0) |-> !$past(wr_en));

    // R2
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status == 3'd0 || status == 3'd2 || status == 3'd3 || status == 3'd4));

    // R11
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !busy);
endmodule

// File: tb/pmt_programmer_bench.sv
`timescale 1ns/1ps
module pmt_programmer_bench;
    localparam int          DEPTH = 16;
    localparam int          IDX_W = 4;
    localparam logic [31:0] VBASE = 32'h3C00_0000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             init_req = 1'b0, req_valid = 1'b0, req_fixed = 1'b0;
    logic [1:0]       req_target = '0;
    logic [31:0]      req_vaddr = '0, req_paddr = '0;
    logic [15:0]      req_psize_kb = '0, req_count = '0;
    logic             busy, done;
    logic [2:0]       status;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [1:0]       rd_target;
    logic [15:0]      rd_ppage;

    int total = 0, bad = 0;
    bit ended = 0;
    logic [1:0]  m_tgt [DEPTH];
    logic [15:0] m_pp  [DEPTH];

    always #2 clk = ~clk;

    pmt_programmer #(.CNT_W(16), .DEPTH(DEPTH), .VBASE(VBASE)) u_pmt_programmer (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .req_valid(req_valid),
        .req_target(req_target), .req_vaddr(req_vaddr), .req_paddr(req_paddr),
        .req_psize_kb(req_psize_kb), .req_count(req_count), .req_fixed(req_fixed),
        .busy(busy), .done(done), .status(status), .rd_idx(rd_idx),
        .rd_target(rd_target), .rd_ppage(rd_ppage)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) begin
            m_tgt[i] = 2'd0;
            m_pp[i]  = 16'hFFFF;
        end
    endtask

    task automatic check_table(input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            rd_idx = IDX_W'(i);
            #0.2;
            chk(tag, 32'(rd_target), 32'(m_tgt[i]));
            chk(tag, 32'(rd_ppage), 32'(m_pp[i]));
        end
        @(negedge clk);
    endtask

    function automatic int exp_status(input logic [31:0] va, input logic [31:0] pa,
                                      input logic [15:0] ps, input logic [15:0] n);
        longint start;
        if (ps != 16'd64) return 3;
        if (va[15:0] != 0 || pa[15:0] != 0) return 2;
        if (va < VBASE) return 4;
        start = longint'((va - VBASE) >> 16);
        if (start + longint'(n) > DEPTH) return 4;
        return 0;
    endfunction

    // called at a falling edge; leaves at a falling edge
    task automatic run_req(input logic [1:0] tgt, input logic [31:0] va, input logic [31:0] pa,
                           input logic [15:0] ps, input logic [15:0] n, input logic fx);
        int es, last, sp;
        string tag;
        es   = exp_status(va, pa, ps, n);
        last = (es != 0 || n == 0) ? 0 : int'(n);
        tag  = (es == 3) ? "R2" : (es == 2) ? "R3" : (es == 4) ? "R4" : "R7";
        req_target = tgt; req_vaddr = va; req_paddr = pa; req_psize_kb = ps;
        req_count = n; req_fixed = fx; req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        for (int k = 0; k <= last; k++) begin
            @(negedge clk);
            if (k < last) begin
                chk("R7 busy", 32'(busy), 32'd1);
                chk("R7 early done", 32'(done), 32'd0);
            end else begin
                chk(tag, 32'(done), 32'd1);
                chk(tag, 32'(status), 32'(es));
                chk("R7 idle", 32'(busy), 32'd0);
            end
        end
        @(negedge clk);
        chk("R7 pulse", 32'(done), 32'd0);
        if (es == 0) begin
            sp = int'((va - VBASE) >> 16);
            for (int i = 0; i < int'(n); i++) begin
                m_tgt[sp+i] = (tgt == 2'd3) ? 2'd0 : tgt;
                m_pp[sp+i]  = fx ? pa[31:16] : 16'(pa[31:16] + 16'(i));
            end
        end
        check_table(es != 0 ? "R6" : (fx ? "R9 R10 R13" : "R8 R10 R13"));
    endtask

    task automatic finish_run();
        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            finish_run();
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 status", 32'(status), 32'd0);
        check_table("R1");

        // R7 R8 R9 R10 R13 sweep of start page and count, including range edge (R4)
        for (int vp = 0; vp <= DEPTH; vp++) begin
            for (int n = 0; n <= DEPTH + 1; n++) begin
                logic [31:0] pa;
                pa = (vp == 3) ? 32'hFFFF_0000 : {16'((vp * 5 + n * 3) & 16'hFFFF), 16'h0};
                run_req(2'((vp * 3 + n) & 3), VBASE + (32'(vp) << 16), pa,
                        16'd64, 16'(n), 1'((vp + n) & 1));
            end
        end

        // R2 R5: bad sizes win over misalignment and range
        run_req(2'd1, VBASE + 32'h100, 32'h10, 16'd0, 16'd40, 1'b0);
        run_req(2'd1, VBASE, 32'h0, 16'd32, 16'd2, 1'b0);
        run_req(2'd2, VBASE, 32'h0, 16'd63, 16'd2, 1'b0);
        run_req(2'd2, VBASE, 32'h0, 16'd128, 16'd2, 1'b0);
        run_req(2'd2, 32'h0, 32'h8000, 16'hFFFF, 16'd2, 1'b1);
        // R3 R5: misalignment wins over range
        run_req(2'd1, VBASE + 32'h100, 32'h0, 16'd64, 16'd40, 1'b0);
        run_req(2'd1, VBASE, 32'h0001_8000, 16'd64, 16'd2, 1'b0);
        run_req(2'd1, 32'h0000_0001, 32'h0, 16'd64, 16'd1, 1'b0);
        // R4
        run_req(2'd1, VBASE - 32'h1_0000, 32'h0, 16'd64, 16'd1, 1'b0);
        run_req(2'd1, VBASE + (32'd100 << 16), 32'h0, 16'd64, 16'd0, 1'b0);
        run_req(2'd1, VBASE + (32'd15 << 16), 32'h0, 16'd64, 16'hFFFF, 1'b0);

        // R11 clear while idle
        init_req = 1'b1;
        @(posedge clk);
        #1 init_req = 1'b0;
        @(negedge clk);
        model_clear();
        check_table("R11 clear");

        // R11 clear beats a simultaneous request
        run_req(2'd1, VBASE, 32'h0005_0000, 16'd64, 16'd4, 1'b0);
        req_target = 2'd2; req_vaddr = VBASE + 32'h8_0000; req_paddr = 32'h0;
        req_psize_kb = 16'd64; req_count = 16'd3; req_fixed = 1'b0;
        req_valid = 1'b1; init_req = 1'b1;
        @(posedge clk);
        #1 begin req_valid = 1'b0; init_req = 1'b0; end
        @(negedge clk);
        chk("R11 no done", 32'(done), 32'd0);
        chk("R11 no busy", 32'(busy), 32'd0);
        model_clear();
        check_table("R11 precedence");

        // R12 request and clear during a run are ignored
        req_target = 2'd1; req_vaddr = VBASE + (32'd2 << 16); req_paddr = 32'h0040_0000;
        req_psize_kb = 16'd64; req_count = 16'd6; req_fixed = 1'b0; req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        req_target = 2'd2; req_vaddr = VBASE + (32'd10 << 16); req_count = 16'd3;
        req_valid = 1'b1;
        @(posedge clk);
        #1 begin req_valid = 1'b0; init_req = 1'b1; end
        @(posedge clk);
        #1 init_req = 1'b0;
        for (int k = 2; k <= 6; k++) begin
            @(negedge clk);
            chk("R12 done timing", 32'(done), (k == 6) ? 32'd1 : 32'd0);
        end
        chk("R12 status", 32'(status), 32'd0);
        for (int i = 0; i < 6; i++) begin
            m_tgt[2+i] = 2'd1;
            m_pp[2+i]  = 16'(16'h40 + 16'(i));
        end
        @(negedge clk);
        check_table("R12 R11 busy");

        finish_run();
    end
endmodule